// File: doc/BRIEF.md
# Page-walk memory request scheduler

This block sits between a page-table walk engine and a memory port that may refuse requests. The walk engine drops at most one table read into a single read slot and pushes accessed-bit write-backs onto a four-deep stack. The scheduler presents one request per cycle on a valid/ready port and tracks how many accepted requests still await a response. The read slot always wins over the stack, and the stack drains newest first.

Once the port refuses a request, the scheduler stops issuing from its slots until a retry strobe arrives. A response may come back negatively acknowledged. The scheduler then reissues that request in the next cycle, ahead of anything pending. If that reissue is also refused, the request goes back to the read slot or onto the stack. A normal read response passes its data straight to the walk engine. A one-cycle done pulse marks the response that leaves no traffic outstanding and nothing queued.

Top module: `walk_req_sched`

## Requirements
- R1: When the read slot and the write-back stack are both occupied and the scheduler is not parked, the read is presented first (req_write = 0). Write-backs follow only after the read has been accepted.
- R2: Write-backs are presented in last-in first-out order: the most recently pushed entry goes first, with its address and data.
- R3: A refused request (req_valid = 1, req_ready = 0) stays in its slot and does not increase inflight. The scheduler then parks, and req_valid stays 0 from the next cycle on.
- R4: A port_retry pulse ends the parked state. The next cycle presents pending work again, in the same priority order.
- R5: A response with rsp_nack = 1 leaves inflight unchanged, and its request (rsp_write, rsp_addr, rsp_wdata) is presented in the next cycle ahead of every slot. If accepted, inflight stays the same. If refused, inflight drops by one, the scheduler parks, and the request returns to the read slot (read) or to the top of the stack (write).
- R6: Each response with rsp_nack = 0 lowers inflight by one, and each accepted request from a slot raises it by one. For a read response (rsp_write = 0), rd_data_valid is 1 and rd_data equals rsp_rdata in the same cycle. For a write response, rd_data_valid stays 0.
- R7: done is high for exactly one cycle. That cycle follows the normal response that leaves inflight at 0, the read slot empty, the stack empty and no reissue pending. done is 0 at every other time.
- R8: The write-back stack holds WB_DEPTH (4) entries. A push while it is full is dropped and sets wb_overflow, which stays set until reset.
- R9: A rd_push while the read slot is occupied is ignored. The first read is issued, and no second read follows.
- R10: After reset, req_valid, done and wb_overflow are 0 and inflight is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_push | input | 1 | Load the read slot |
| rd_push_addr | input | AW | Table read address |
| wb_push | input | 1 | Push a write-back onto the stack |
| wb_push_addr | input | AW | Write-back address |
| wb_push_data | input | DW | Write-back data |
| req_valid | output | 1 | Request presented to the port |
| req_ready | input | 1 | Port accepts the presented request |
| req_write | output | 1 | 1 = write-back, 0 = read |
| req_addr | output | AW | Request address |
| req_data | output | DW | Write data (0 for reads) |
| port_retry | input | 1 | Port can take requests again |
| rsp_valid | input | 1 | Response present |
| rsp_nack | input | 1 | Response is a negative acknowledgement |
| rsp_write | input | 1 | Response belongs to a write-back |
| rsp_addr | input | AW | Address of the responded request |
| rsp_wdata | input | DW | Write data of the responded request |
| rsp_rdata | input | DW | Read data |
| rd_data_valid | output | 1 | Read data handed to the walk engine |
| rd_data | output | DW | Read data |
| inflight | output | CNT_W | Accepted requests without a response |
| done | output | 1 | One-cycle pulse: all traffic drained |
| wb_overflow | output | 1 | Sticky: a write-back push was dropped |

## Verification
The hardest situation to reach is a refused reissue of a negatively acknowledged write while another write-back sits on the stack. The returned entry must land above the queued one, and the count must drop. The bench gets there in three steps. It has one write accepted. It then returns a nack for that write in the same cycle that it pushes a second write. Finally, it holds req_ready low in the reissue cycle, releases with a retry strobe, and checks that the reissued write comes out before the second. A sweep over 0 to 4 queued write-backs, with the port refusing at first, covers the ordering, the parking and the placement of the done pulse for every stack fill level.

// File: rtl/walk_req_sched.sv
module walk_req_sched #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_push,
  input  logic [AW-1:0] rd_push_addr,
  input  logic          wb_push,
  input  logic [AW-1:0] wb_push_addr,
  input  logic [DW-1:0] wb_push_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          port_retry,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic          rsp_write,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_wdata,
  input  logic [DW-1:0] rsp_rdata,
  output logic          rd_data_valid,
  output logic [DW-1:0] rd_data,
  output logic [CNT_W-1:0] inflight,
  output logic          done,
  output logic          wb_overflow
);
  localparam int SP_W  = $clog2(WB_DEPTH + 1);
  localparam int IDX_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;

  logic          rd_pend;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] st_addr [WB_DEPTH];
  logic [DW-1:0] st_data [WB_DEPTH];
  logic [SP_W-1:0] st_cnt;
  logic          parked;
  logic          nk_pend, nk_write;
  logic [AW-1:0] nk_addr;
  logic [DW-1:0] nk_data;
  logic [CNT_W-1:0] infl;
  logic          done_q, ovf_q;

  logic [IDX_W-1:0] top_idx;
  logic sel_nk, sel_rd, sel_wb, refuse, nk_back, rsp_ok;

  assign top_idx = (st_cnt != '0) ? IDX_W'(st_cnt - 1'b1) : '0;
  assign sel_nk  = nk_pend;
  assign sel_rd  = !nk_pend && !parked && rd_pend;
  assign sel_wb  = !nk_pend && !parked && !rd_pend && (st_cnt != '0);

  assign req_valid = sel_nk || sel_rd || sel_wb;
  assign req_write = sel_nk ? nk_write : sel_wb;
  assign req_addr  = sel_nk ? nk_addr : (sel_rd ? rd_addr : st_addr[top_idx]);
  assign req_data  = sel_nk ? nk_data : (sel_wb ? st_data[top_idx] : '0);

  assign refuse  = req_valid && !req_ready;
  assign nk_back = sel_nk && !req_ready;
  assign rsp_ok  = rsp_valid && !rsp_nack;

  assign rd_data_valid = rsp_ok && !rsp_write;
  assign rd_data       = rsp_rdata;
  assign inflight      = infl;
  assign done          = done_q;
  assign wb_overflow   = ovf_q;

  logic [AW-1:0] n_addr [WB_DEPTH];
  logic [DW-1:0] n_data [WB_DEPTH];
  logic [SP_W-1:0] n_cnt;
  logic ovf_set;

  always_comb begin
    n_addr  = st_addr;
    n_data  = st_data;
    n_cnt   = st_cnt;
    ovf_set = 1'b0;
    if (sel_wb && req_ready) n_cnt = n_cnt - 1'b1;
    if (nk_back && nk_write) begin
      if (n_cnt < SP_W'(WB_DEPTH)) begin
        n_addr[IDX_W'(n_cnt)] = nk_addr;
        n_data[IDX_W'(n_cnt)] = nk_data;
        n_cnt = n_cnt + 1'b1;
      end else ovf_set = 1'b1;
    end
    if (wb_push) begin
      if (n_cnt < SP_W'(WB_DEPTH)) begin
        n_addr[IDX_W'(n_cnt)] = wb_push_addr;
        n_data[IDX_W'(n_cnt)] = wb_push_data;
        n_cnt = n_cnt + 1'b1;
      end else ovf_set = 1'b1;
    end
  end

  logic          n_rd_pend;
  logic [AW-1:0] n_rd_addr;

  always_comb begin
    n_rd_pend = rd_pend;
    n_rd_addr = rd_addr;
    if (sel_rd && req_ready) n_rd_pend = 1'b0;
    if (nk_back && !nk_write) begin
      n_rd_pend = 1'b1;
      n_rd_addr = nk_addr;
    end else if (rd_push && !rd_pend) begin
      n_rd_pend = 1'b1;
      n_rd_addr = rd_push_addr;
    end
  end

  logic [CNT_W-1:0] n_infl;
  assign n_infl = infl + CNT_W'(req_valid && req_ready && !sel_nk)
                       - CNT_W'(rsp_ok) - CNT_W'(nk_back);

  always_ff @(posedge clk) begin
    st_addr <= n_addr;
    st_data <= n_data;
    rd_addr <= n_rd_addr;
    if (rsp_valid && rsp_nack) begin
      nk_write <= rsp_write;
      nk_addr  <= rsp_addr;
      nk_data  <= rsp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      st_cnt  <= '0;
      parked  <= 1'b0;
      nk_pend <= 1'b0;
      infl    <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      rd_pend <= n_rd_pend;
      st_cnt  <= n_cnt;
      if (refuse) parked <= 1'b1;
      else if (port_retry) parked <= 1'b0;
      nk_pend <= rsp_valid && rsp_nack;
      infl    <= n_infl;
      done_q  <= rsp_ok && (n_infl == '0) && !n_rd_pend && (n_cnt == '0);
      ovf_q   <= ovf_q || ovf_set;
    end
  end

  AST_READ_BEFORE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && st_cnt != '0 && !parked && !nk_pend) |-> (req_valid && !req_write)); // R1
  AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !nk_pend) |-> !req_valid); // R3
  AST_REFUSE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !nk_pend) |=> (infl <= $past(infl))); // R3
  AST_RETRY_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (port_retry && !refuse) |=> !parked); // R4
  AST_NACK_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack) |=> (req_valid && req_addr == $past(rsp_addr))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (infl != '0)); // R6
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (infl == '0 && !rd_pend && st_cnt == '0 && !nk_pend)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_cnt <= SP_W'(WB_DEPTH)); // R8
endmodule

// File: tb/walk_req_sched_tb.sv
module walk_req_sched_tb;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_push = 0, wb_push = 0, req_ready = 0, port_retry = 0;
  logic rsp_valid = 0, rsp_nack = 0, rsp_write = 0;
  logic [AW-1:0] rd_push_addr = '0, wb_push_addr = '0, rsp_addr = '0;
  logic [DW-1:0] wb_push_data = '0, rsp_wdata = '0, rsp_rdata = '0;
  logic req_valid, req_write, rd_data_valid, done, wb_overflow;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data, rd_data;
  logic [CW-1:0] inflight;

  int n_cmp = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  walk_req_sched #(.AW(AW), .DW(DW), .WB_DEPTH(4), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_push(rd_push), .rd_push_addr(rd_push_addr),
    .wb_push(wb_push), .wb_push_addr(wb_push_addr), .wb_push_data(wb_push_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .port_retry(port_retry),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_write(rsp_write),
    .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .inflight(inflight), .done(done), .wb_overflow(wb_overflow));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    rd_push = 0; wb_push = 0; port_retry = 0;
    rsp_valid = 0; rsp_nack = 0; rsp_write = 0;
  endtask

  function automatic logic [DW-1:0] wdat(input int n, input int i);
    return 64'(32'hD000 + n * 16 + i);
  endfunction

  task automatic expect_req(input string tag, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    check({tag, " valid"}, req_valid, 1'b1);
    check({tag, " write"}, req_write, wr);
    check({tag, " addr"}, req_addr, a);
    if (wr) check({tag, " data"}, req_data, d);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    #1;
    check("R10 req_valid", req_valid, 0);
    check("R10 inflight", inflight, 0);
    check("R10 done", done, 0);
    check("R10 overflow", wb_overflow, 0);
    cyc(); rst_n = 1;

    // Sweep: 0..4 write-backs behind one read, port refusing at first
    for (int n = 0; n <= 4; n++) begin
      cyc(); req_ready = 0; rd_push = 1; rd_push_addr = 32'h40 + n;
      cyc(); #1;
      expect_req("R1 offered read", 0, 32'h40 + n, '0);
      for (int i = 0; i < n; i++) begin
        cyc(); wb_push = 1; wb_push_addr = 32'h100 + i; wb_push_data = wdat(n, i); #1;
        check("R3 parked no req", req_valid, 0);
      end
      cyc(); #1;
      check("R3 parked no req", req_valid, 0);
      check("R3 refused not counted", inflight, 0);
      cyc(); port_retry = 1; req_ready = 1; #1;
      check("R4 parked in retry cycle", req_valid, 0);
      cyc(); #1;
      expect_req("R1 read first", 0, 32'h40 + n, '0);
      for (int k = n - 1; k >= 0; k--) begin
        cyc(); #1;
        expect_req("R2 lifo", 1, 32'h100 + k, wdat(n, k));
      end
      cyc(); #1;
      check("R2 drained", req_valid, 0);
      check("R6 inflight count", inflight, n + 1);
      cyc(); rsp_valid = 1; rsp_write = 0; rsp_rdata = 64'hBEEF0000 + n; #1;
      check("R6 rd_data_valid", rd_data_valid, 1);
      check("R6 rd_data", rd_data, 64'hBEEF0000 + n);
      for (int j = 0; j < n; j++) begin
        cyc(); rsp_valid = 1; rsp_write = 1; #1;
        check("R6 write rsp no data", rd_data_valid, 0);
        check("R6 inflight dec", inflight, n - j);
        check("R7 no early done", done, 0);
      end
      cyc(); #1;
      check("R7 done pulse", done, 1);
      check("R6 inflight zero", inflight, 0);
      cyc(); #1;
      check("R7 done one cycle", done, 0);
    end

    // Nacked read: reissue accepted, then reissue refused
    cyc(); req_ready = 1; rd_push = 1; rd_push_addr = 32'h80;
    cyc(); #1; expect_req("R5 setup read", 0, 32'h80, '0);
    cyc(); rsp_valid = 1; rsp_nack = 1; rsp_write = 0; rsp_addr = 32'h80; #1;
    check("R5 inflight before nack", inflight, 1);
    cyc(); #1; expect_req("R5 reissue", 0, 32'h80, '0);
    cyc(); #1;
    check("R5 reissue not counted", inflight, 1);
    check("R7 no done on nack", done, 0);
    cyc(); rsp_valid = 1; rsp_nack = 1; rsp_write = 0; rsp_addr = 32'h80;
    cyc(); req_ready = 0; #1; expect_req("R5 reissue refused", 0, 32'h80, '0);
    cyc(); #1;
    check("R5 refused reissue dec", inflight, 0);
    check("R5 parked", req_valid, 0);
    cyc(); port_retry = 1; req_ready = 1;
    cyc(); #1; expect_req("R5 back in read slot", 0, 32'h80, '0);
    cyc(); #1; check("R5 recount", inflight, 1);
    cyc(); rsp_valid = 1; rsp_rdata = 64'h1234; #1;
    check("R6 rd_data", rd_data, 64'h1234);
    cyc(); #1; check("R7 done after nack flow", done, 1);

    // Nacked write ahead of a queued write, refused, returns on top
    cyc(); req_ready = 1; wb_push = 1; wb_push_addr = 32'h200; wb_push_data = 64'h55;
    cyc(); #1; expect_req("R5 setup write", 1, 32'h200, 64'h55);
    cyc(); rsp_valid = 1; rsp_nack = 1; rsp_write = 1; rsp_addr = 32'h200; rsp_wdata = 64'h55;
    wb_push = 1; wb_push_addr = 32'h210; wb_push_data = 64'h66;
    cyc(); req_ready = 0; #1; expect_req("R5 nack ahead of stack", 1, 32'h200, 64'h55);
    cyc(); #1;
    check("R5 write refused dec", inflight, 0);
    check("R3 parked", req_valid, 0);
    cyc(); port_retry = 1; req_ready = 1;
    cyc(); #1; expect_req("R5 returned on top", 1, 32'h200, 64'h55);
    cyc(); #1; expect_req("R2 older write after", 1, 32'h210, 64'h66);
    cyc(); #1; check("R6 two in flight", inflight, 2);
    cyc(); rsp_valid = 1; rsp_write = 1;
    cyc(); rsp_valid = 1; rsp_write = 1; #1; check("R7 not yet", done, 0);
    cyc(); #1; check("R7 done", done, 1);

    // Overflow and ignored second read
    cyc(); req_ready = 0; rd_push = 1; rd_push_addr = 32'h300;
    cyc(); rd_push = 1; rd_push_addr = 32'h310;
    for (int i = 0; i < 5; i++) begin
      cyc(); wb_push = 1; wb_push_addr = 32'h400 + i; wb_push_data = wdat(9, i); #1;
      check("R8 no overflow yet", wb_overflow, 0);
    end
    cyc(); #1; check("R8 overflow set", wb_overflow, 1);
    cyc(); port_retry = 1; req_ready = 1;
    cyc(); #1; expect_req("R9 first read kept", 0, 32'h300, '0);
    for (int k = 3; k >= 0; k--) begin
      cyc(); #1; expect_req("R8 fifth push dropped", 1, 32'h400 + k, wdat(9, k));
    end
    cyc(); #1;
    check("R9 no second read", req_valid, 0);
    check("R6 five in flight", inflight, 5);
    cyc(); rsp_valid = 1; rsp_write = 0;
    for (int j = 0; j < 4; j++) begin
      cyc(); rsp_valid = 1; rsp_write = 1;
    end
    cyc(); #1;
    check("R7 done after overflow flow", done, 1);
    check("R8 overflow sticky", wb_overflow, 1);
    cyc(); rst_n = 0;
    cyc(); rst_n = 1; #1;
    check("R10 overflow cleared", wb_overflow, 0);
    check("R10 no req", req_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule